// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block sits between an 8-bit CPU with a 16-bit address bus and its memories. It splits the address space into four 16 KB windows. The lowest window reaches ROM. The next window reaches video RAM. The third window always reaches one fixed RAM bank. The top window reaches whichever of 32 RAM banks software has selected. The block produces the chip selects and write enables. It also produces the bank number, the word address and the byte-lane selects for an external SRAM that is 16 bits wide. The top bank bit picks the byte lane, so one half-size 16-bit device stores all 32 banks.

Software writes a control byte through an I/O port that is only partly decoded. The five bank bits are spread across the byte. Three further bits select the shown screen and the ROM bank, and lock the register. While the lock is set, port writes are ignored. The lock clears only on reset or when the unlock input is pulsed. All writes are gated by the CPU clock enable.

Top module: `bank_pager`

## Requirements
- R1: With mem_rd or mem_wr high, exactly one select is high: rom_cs for addr[15:14]=0, vram_cs for 1, sram_cs for 2 or 3. With neither strobe high, no select is high.
- R2: For addresses 0x8000–0xBFFF, bank is always 2, so lane_lo is high and sram_addr[17:14]=4'b0010.
- R3: For addresses 0xC000–0xFFFF, bank = {ctrl[7], ctrl[6], ctrl[2], ctrl[1], ctrl[0]}, where ctrl is the last accepted port byte.
- R4: When sram_cs is high, lane_hi = bank[4], lane_lo = !bank[4], and sram_addr = {bank[3:0], addr[13:0]}. Both lanes are low when sram_cs is low.
- R5: screen_sel follows ctrl[3], rom_bank follows ctrl[4], and locked follows ctrl[5].
- R6: A port write is a cycle with io_wr=1, addr[15]=0, addr[14]=1 and addr[1]=0. Every other address bit is ignored.
- R7: Port writes and memory write enables (sram_we, vram_we) take effect only while cpu_en is high.
- R8: While locked is high, port writes leave the control byte unchanged.
- R9: A cycle with unlock high clears locked whatever cpu_en is. A port write that arrives in the same cycle while locked is still ignored. An accepted write that arrives in the same cycle as unlock keeps its other bits, but the lock stays clear.
- R10: After reset the control byte is zero: bank 0 for the top window, screen 0, ROM bank 0, unlocked.
- R11: A memory write to the ROM window raises no write enable. A write to the video window raises vram_we, and a write to either RAM window raises sram_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | CPU clock enable; gates all writes |
| addr | input | 16 | CPU address bus |
| data_in | input | 8 | CPU data bus, used for port writes |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_wr | input | 1 | I/O write strobe |
| unlock | input | 1 | Clears the lock bit |
| rom_cs | output | 1 | ROM window select |
| vram_cs | output | 1 | Video RAM window select |
| sram_cs | output | 1 | Banked SRAM select |
| vram_we | output | 1 | Video RAM write enable |
| sram_we | output | 1 | SRAM write enable |
| bank | output | 5 | Bank number for the current address |
| sram_addr | output | 18 | SRAM word address |
| lane_hi | output | 1 | Upper byte lane select |
| lane_lo | output | 1 | Lower byte lane select |
| screen_sel | output | 1 | Displayed screen select |
| rom_bank | output | 1 | ROM bank select |
| locked | output | 1 | Paging lock state |

## Verification
The unlock pulse and a port write can land on the same clock edge. The bench forces this in both states. When the register is locked, it pairs unlock with a write and checks that the old bank survives while the lock reads clear. When the register is unlocked, it pairs unlock with a byte that has the lock bit set, and checks that the new bank is taken but the lock stays clear. The bench also sweeps all 256 control bytes and all 256 upper address bytes, for both port decoding and region decoding, and computes each expected bank, lane and word address from the bit mapping.

// File: rtl/bank_pager.sv
module bank_pager #(
  parameter int FIXED_BANK = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_en,
  input  logic [15:0] addr,
  input  logic [7:0]  data_in,
  input  logic        mem_rd,
  input  logic        mem_wr,
  input  logic        io_wr,
  input  logic        unlock,
  output logic        rom_cs,
  output logic        vram_cs,
  output logic        sram_cs,
  output logic        vram_we,
  output logic        sram_we,
  output logic [4:0]  bank,
  output logic [17:0] sram_addr,
  output logic        lane_hi,
  output logic        lane_lo,
  output logic        screen_sel,
  output logic        rom_bank,
  output logic        locked
);
  localparam int OFFS_W = 14;
  localparam logic [4:0] FB = 5'(FIXED_BANK);

  logic [7:0] ctrl;
  logic [1:0] region;
  logic       mem_act, port_hit, port_take;
  logic [4:0] paged;

  assign region    = addr[15:14];
  assign mem_act   = mem_rd | mem_wr;
  assign port_hit  = io_wr & ~addr[15] & addr[14] & ~addr[1];
  assign port_take = port_hit & cpu_en & ~ctrl[5];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= 8'h00;
    else begin
      if (port_take) ctrl <= data_in;
      if (unlock) ctrl[5] <= 1'b0;
    end
  end

  assign paged = {ctrl[7], ctrl[6], ctrl[2:0]};
  assign bank  = (region == 2'b10) ? FB : paged;

  assign rom_cs  = mem_act & (region == 2'b00);
  assign vram_cs = mem_act & (region == 2'b01);
  assign sram_cs = mem_act & region[1];
  assign vram_we = vram_cs & mem_wr & cpu_en;
  assign sram_we = sram_cs & mem_wr & cpu_en;

  assign sram_addr = {bank[3:0], addr[OFFS_W-1:0]};
  assign lane_hi   = sram_cs & bank[4];
  assign lane_lo   = sram_cs & ~bank[4];

  assign screen_sel = ctrl[3];
  assign rom_bank   = ctrl[4];
  assign locked     = ctrl[5];

  p_one_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, vram_cs, sram_cs}));
  p_fixed_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_cs && region == 2'b10) |-> (bank == FB));
  p_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs |-> (lane_hi ^ lane_lo));
  p_gated_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |-> (!sram_we && !vram_we));
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !unlock) |=> $stable(ctrl));
  p_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> !locked);
  p_rom_no_we_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> (!sram_we && !vram_we));
endmodule

// File: tb/bank_pager_test.sv
module bank_pager_test;
  logic clk = 0, rst_n = 0, cpu_en = 0, mem_rd = 0, mem_wr = 0, io_wr = 0, unlock = 0;
  logic [15:0] addr = 0;
  logic [7:0]  data_in = 0;
  logic rom_cs, vram_cs, sram_cs, vram_we, sram_we, lane_hi, lane_lo, screen_sel, rom_bank, locked;
  logic [4:0]  bank;
  logic [17:0] sram_addr;
  int n_chk = 0, n_fail = 0;

  bank_pager uut (.clk, .rst_n, .cpu_en, .addr, .data_in, .mem_rd, .mem_wr, .io_wr, .unlock,
    .rom_cs, .vram_cs, .sram_cs, .vram_we, .sram_we, .bank, .sram_addr,
    .lane_hi, .lane_lo, .screen_sel, .rom_bank, .locked);

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic port_wr(input logic [15:0] a, input logic [7:0] d, input logic en, input logic ul);
    @(negedge clk);
    addr = a; data_in = d; io_wr = 1; cpu_en = en; unlock = ul; mem_rd = 0; mem_wr = 0;
    @(posedge clk);
    @(negedge clk);
    io_wr = 0; unlock = 0; cpu_en = 1;
  endtask

  task automatic probe(input logic [15:0] a, input logic rd, input logic wr, input logic en);
    @(negedge clk);
    addr = a; mem_rd = rd; mem_wr = wr; cpu_en = en;
    #1;
  endtask

  function automatic logic [4:0] map_bank(input logic [7:0] d);
    return {d[7], d[6], d[2:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; cpu_en = 1;
    probe(16'hC123, 1, 0, 1);
    chk(bank == 0, "R10 bank", bank, 0);
    chk({screen_sel, rom_bank, locked} == 0, "R10 flags", {screen_sel, rom_bank, locked}, 0);

    for (int d = 0; d < 256; d++) begin
      logic [7:0] b = 8'(d);
      logic [4:0] eb = map_bank(b);
      logic [15:0] a = 16'hC000 | 16'((d * 37) & 16'h3FFF);
      port_wr(16'h7FFD, b, 1, 0);
      probe(a, 1, 0, 1);
      chk(bank == eb, "R3 bank", bank, eb);
      chk({screen_sel, rom_bank, locked} == {b[3], b[4], b[5]}, "R5 flags",
          {screen_sel, rom_bank, locked}, {b[3], b[4], b[5]});
      chk(lane_hi == eb[4] && lane_lo == !eb[4], "R4 lane", {lane_hi, lane_lo}, {eb[4], !eb[4]});
      chk(sram_addr == {eb[3:0], a[13:0]}, "R4 addr", sram_addr, {eb[3:0], a[13:0]});
      if (b[5]) begin
        @(negedge clk); unlock = 1; cpu_en = 0; mem_rd = 0;
        @(posedge clk); @(negedge clk); unlock = 0; cpu_en = 1; #1;
        chk(locked == 0, "R9 unlock", locked, 0);
      end
    end

    port_wr(16'h7FFD, 8'h83, 1, 0);
    for (int h = 0; h < 256; h++) begin
      logic [15:0] a = {8'(h), 8'(h) ^ 8'h5A};
      logic [1:0] rg = a[15:14];
      logic [4:0] eb = (rg == 2) ? 5'd2 : 5'h13;
      probe(a, 0, 0, 1);
      chk({rom_cs, vram_cs, sram_cs} == 0, "R1 idle", {rom_cs, vram_cs, sram_cs}, 0);
      probe(a, 1, 0, 1);
      chk({rom_cs, vram_cs, sram_cs} == {rg == 0, rg == 1, rg[1]}, "R1 select",
          {rom_cs, vram_cs, sram_cs}, {rg == 0, rg == 1, rg[1]});
      chk(vram_we == 0 && sram_we == 0, "R11 read no we", {vram_we, sram_we}, 0);
      if (rg[1]) begin
        chk(bank == eb, "R2 bank", bank, eb);
        chk(sram_addr == {eb[3:0], a[13:0]} && lane_hi == eb[4] && lane_lo == !eb[4],
            "R2 addr", sram_addr, {eb[3:0], a[13:0]});
      end else chk(!lane_hi && !lane_lo, "R4 no lane", {lane_hi, lane_lo}, 0);
      probe(a, 0, 1, 1);
      chk({vram_we, sram_we} == {rg == 1, rg[1]}, "R11 we", {vram_we, sram_we}, {rg == 1, rg[1]});
      probe(a, 0, 1, 0);
      chk({vram_we, sram_we} == 0, "R7 we gated", {vram_we, sram_we}, 0);
    end

    for (int h = 0; h < 256; h++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] lo = (k == 0) ? 8'hFD : (k == 1) ? 8'hFF : 8'h00;
        logic [15:0] a = {8'(h), lo};
        logic hit = !a[15] && a[14] && !a[1];
        port_wr(16'h7FFD, 8'h00, 1, 0);
        port_wr(a, 8'h05, 1, 0);
        probe(16'hC000, 1, 0, 1);
        chk(bank == (hit ? 5'd5 : 5'd0), "R6 decode", bank, hit ? 5 : 0);
      end
    end

    port_wr(16'h7FFD, 8'h01, 1, 0);
    port_wr(16'h7FFD, 8'h06, 0, 0);
    probe(16'hC000, 1, 0, 1);
    chk(bank == 1, "R7 port gated", bank, 1);

    port_wr(16'h7FFD, 8'h21, 1, 0);
    port_wr(16'h7FFD, 8'h07, 1, 0);
    probe(16'hC000, 1, 0, 1);
    chk(bank == 1 && locked, "R8 locked hold", bank, 1);
    port_wr(16'h7FFD, 8'h07, 1, 1);
    probe(16'hC000, 1, 0, 1);
    chk(bank == 1 && !locked, "R9 unlock with write", {locked, bank}, 1);
    port_wr(16'h7FFD, 8'hE8, 1, 1);
    probe(16'hC000, 1, 0, 1);
    chk(bank == 5'h18 && !locked && screen_sel, "R9 write with unlock", {locked, bank}, 5'h18);
    port_wr(16'h7FFD, 8'h22, 1, 0);
    port_wr(16'h7FFD, 8'h00, 0, 1);
    probe(16'hC000, 1, 0, 1);
    chk(!locked && bank == 2, "R9 unlock no enable", {locked, bank}, 2);

    @(negedge clk); rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
    probe(16'hFFFF, 1, 0, 1);
    chk(bank == 0 && !locked && !screen_sel, "R10 second reset", bank, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule